// File: doc/BRIEF.md
# Push-Pull PWM Steering Controller

This block generates the switching pulses for a push-pull converter stage. A free-running counter marks out each switching period. Its value is compared against a duty-command word, and the pulse produced in each period goes to one of two gate-drive enables. The steering alternates between the two enables, so the two power switches run 180 degrees apart.

Every period opens with a programmable blanking interval. During blanking both enables are held off, which gives the dead time between the two switches. A per-period latch allows only one pulse per period. Once a pulse has ended, or a current-limit flag has cut it short, the enables stay off until the next period, even if the command word moves back and forth.

A shutdown input cuts both enables at once but leaves the period counter running. After shutdown is released, the enables stay off until the next period boundary. The steering only advances at the end of a period that actually produced a pulse, so the same switch is never driven twice in a row. An external sync input restarts the period. Sync is filtered: it must be seen high on two consecutive clock samples, so short glitches are ignored.

Top module: `pushpull_pwm`

## Requirements
- R1: While reset is held and in the first cycle after it, both enables are low and the period strobe is high. No pulse is issued in the first period after reset, and output A receives the first pulse.
- R2: With no sync activity, the period lasts `periodMax`+1 clock cycles. The period strobe is high only in the first cycle of each period, where the ramp count is 0.
- R3: The enables are never high together. Each new pulse appears on the enable opposite to the previous pulse. The steering advances only at the end of a period in which a pulse was issued.
- R4: Both enables are low in every cycle whose ramp count is below `blankLen`.
- R5: An enable is high when the ramp count is at least `blankLen` and below `dutyCmd`. A command at or below `blankLen` gives no pulse. A command above `periodMax` gives the longest pulse, `periodMax`+1−`blankLen` cycles.
- R6: Once a pulse has ended within a period, no enable goes high again in that period, even if the compare turns true again.
- R7: While `shutdown` is high, both enables are low in that same cycle. The period timing is not changed.
- R8: After `shutdown` falls, both enables stay low until the next period starts.
- R9: Sync must be sampled high at two consecutive rising edges, k and k+1, after a low sample. The period strobe then rises in the cycle after edge k+3. A sync seen high at only one edge has no effect.
- R10: While `curLimit` is high, both enables are low in the same cycle. They remain low for the rest of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodMax | input | CNT_W | Terminal ramp count; period is periodMax+1 cycles |
| blankLen | input | CNT_W | Blanking length in cycles at the start of each period |
| dutyCmd | input | CNT_W | Compare word; enable is on while ramp count is below it |
| syncIn | input | 1 | External period restart, asynchronous |
| shutdown | input | 1 | Synchronous active-high forced off |
| curLimit | input | 1 | Synchronous active-high pulse termination |
| gateA | output | 1 | Gate-drive enable A |
| gateB | output | 1 | Gate-drive enable B |
| periodStart | output | 1 | High in the first cycle of each period |

## Verification
Shutdown, current limit and the duty compare act on the enables within the same cycle. Counter, steering and latch effects appear one edge after the period event. A sync restart appears four edges after the first high sample. A per-edge reference model advances with the same sampled inputs and is compared two nanoseconds after every rising edge. Inputs change only just after falling edges, so the inputs a cycle ends with are the ones the model consumes. Directed measurements count cycles from a period strobe, sampled one nanosecond after falling edges, so each count of period length, pulse width or restart delay maps directly to ramp counts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Status strobes from the ramp datapath to the steering control
  typedef struct packed {
    logic termHit;   // ramp reached its terminal value
    logic syncFire;  // filtered external restart
    logic cmpOn;     // ramp below the duty command
    logic inBlank;   // ramp inside the blanking window
    logic atStart;   // first cycle of a period
  } rampStat_t;

  // Strobes from the steering control back to the datapath
  typedef struct packed {
    logic restart;   // clear the ramp at the next edge
  } rampCtl_t;

endpackage

// File: rtl/pwm_ramp_dp.sv
module pwm_ramp_dp
  import pwm_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int SYNC_DEPTH    = 2,
  parameter int SYNC_MIN_HIGH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodMax,
  input  logic [CNT_W-1:0] blankLen,
  input  logic [CNT_W-1:0] dutyCmd,
  input  logic             syncIn,
  input  rampCtl_t         ctl,
  output rampStat_t        stat,
  output logic [CNT_W-1:0] rampCnt
);

  localparam int CHAIN = SYNC_DEPTH + SYNC_MIN_HIGH;

  // Bit 0 holds the newest sample; older samples move up.
  logic [CHAIN-1:0] syncSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncSh <= '0;
    else       syncSh <= {syncSh[CHAIN-2:0], syncIn};
  end

  // Restart once the sync level has held for SYNC_MIN_HIGH samples past
  // the synchronizer, following a low sample.
  logic syncHeld;
  assign syncHeld = &syncSh[SYNC_DEPTH-1 +: SYNC_MIN_HIGH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rampCnt <= '0;
    else if (ctl.restart) rampCnt <= '0;
    else                  rampCnt <= rampCnt + 1'b1;
  end

  always_comb begin
    stat.termHit  = (rampCnt >= periodMax);
    stat.syncFire = syncHeld & ~syncSh[CHAIN-1];
    stat.cmpOn    = (rampCnt < dutyCmd);
    stat.inBlank  = (rampCnt < blankLen);
    stat.atStart  = (rampCnt == '0);
  end

endmodule

// File: rtl/pwm_steer_ctl.sv
module pwm_steer_ctl
  import pwm_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  rampStat_t        stat,
  input  logic             shutdown,
  input  logic             curLimit,
  output rampCtl_t         ctl,
  output logic [N_OUT-1:0] gates
);

  localparam int SW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam logic [SW-1:0] LAST_IDX = SW'(N_OUT - 1);

  logic          periodEnd;
  logic          pulseNow;
  logic          pulseDone;   // one-pulse latch
  logic          wasOn;       // pulse was active last cycle
  logic          firedThis;   // a pulse happened in this period
  logic          armed;       // cleared by shutdown, set at period end
  logic [SW-1:0] steer;

  assign periodEnd   = stat.termHit | stat.syncFire;
  assign ctl.restart = periodEnd;

  assign pulseNow = stat.cmpOn & ~stat.inBlank & ~pulseDone
                  & ~curLimit & ~shutdown & armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseDone <= 1'b0;
      wasOn     <= 1'b0;
      firedThis <= 1'b0;
    end else if (periodEnd) begin
      pulseDone <= 1'b0;
      wasOn     <= 1'b0;
      firedThis <= 1'b0;
    end else begin
      pulseDone <= pulseDone | curLimit | (wasOn & ~pulseNow);
      wasOn     <= pulseNow;
      firedThis <= firedThis | pulseNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (shutdown)  armed <= 1'b0;
    else if (periodEnd) armed <= 1'b1;
  end

  // Steering advances only past a period that issued a pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) steer <= '0;
    else if (periodEnd && (firedThis || pulseNow))
      steer <= (steer == LAST_IDX) ? '0 : steer + 1'b1;
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_route
    assign gates[i] = pulseNow & (steer == SW'(i));
  end

endmodule

// File: rtl/pushpull_pwm.sv
module pushpull_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int SYNC_DEPTH    = 2,
  parameter int SYNC_MIN_HIGH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodMax,
  input  logic [CNT_W-1:0] blankLen,
  input  logic [CNT_W-1:0] dutyCmd,
  input  logic             syncIn,
  input  logic             shutdown,
  input  logic             curLimit,
  output logic             gateA,
  output logic             gateB,
  output logic             periodStart
);

  localparam int N_OUT = 2;

  rampStat_t        stat;
  rampCtl_t         ctl;
  logic [CNT_W-1:0] rampCnt;
  logic [N_OUT-1:0] gates;

  pwm_ramp_dp #(
    .CNT_W(CNT_W), .SYNC_DEPTH(SYNC_DEPTH), .SYNC_MIN_HIGH(SYNC_MIN_HIGH)
  ) u_ramp (
    .clk(clk), .rstN(rstN), .periodMax(periodMax), .blankLen(blankLen),
    .dutyCmd(dutyCmd), .syncIn(syncIn), .ctl(ctl), .stat(stat),
    .rampCnt(rampCnt)
  );

  pwm_steer_ctl #(.N_OUT(N_OUT)) u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .shutdown(shutdown),
    .curLimit(curLimit), .ctl(ctl), .gates(gates)
  );

  assign gateA       = gates[0];
  assign gateB       = gates[1];
  assign periodStart = stat.atStart;

endmodule

// File: rtl/pushpull_pwm_chk.sv
module pushpull_pwm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             gateA,
  input logic             gateB,
  input logic             periodStart,
  input logic             shutdown,
  input logic             curLimit,
  input logic [CNT_W-1:0] rampCnt,
  input logic [CNT_W-1:0] blankLen
);

  logic anyOn, anyQ, endSeen, hasLast, lastB;
  assign anyOn = gateA | gateB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anyQ <= 1'b0; endSeen <= 1'b0; hasLast <= 1'b0; lastB <= 1'b0;
    end else begin
      anyQ    <= anyOn;
      endSeen <= periodStart ? 1'b0 : (endSeen | (anyQ & ~anyOn));
      if (gateA && !anyQ)      begin hasLast <= 1'b1; lastB <= 1'b0; end
      else if (gateB && !anyQ) begin hasLast <= 1'b1; lastB <= 1'b1; end
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(gateA && gateB)); // R3
  AST_ALTERNATE_A: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateA) |-> (!hasLast || lastB)); // R3
  AST_ALTERNATE_B: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateB) |-> (hasLast && !lastB)); // R3
  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rampCnt < blankLen) |-> !anyOn); // R4
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (endSeen && !periodStart) |-> !anyOn); // R6
  AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |-> !anyOn); // R7
  AST_REARM_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shutdown) |-> !anyOn); // R8
  AST_CLIM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    curLimit |-> !anyOn); // R10

endmodule

bind pushpull_pwm pushpull_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .gateA(gateA), .gateB(gateB),
  .periodStart(periodStart), .shutdown(shutdown), .curLimit(curLimit),
  .rampCnt(rampCnt), .blankLen(blankLen)
);

// File: tb/tb_pushpull_pwm.sv
`timescale 1ns/100ps
module tb_pushpull_pwm;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] periodMax = 8'd19;
  logic [7:0] blankLen = 8'd3;
  logic [7:0] dutyCmd = 8'd10;
  logic       syncIn = 1'b0;
  logic       shutdown = 1'b0;
  logic       curLimit = 1'b0;
  logic       gateA, gateB, periodStart;

  always #2.5 clk = ~clk;

  pushpull_pwm dut (
    .clk(clk), .rstN(rstN), .periodMax(periodMax), .blankLen(blankLen),
    .dutyCmd(dutyCmd), .syncIn(syncIn), .shutdown(shutdown),
    .curLimit(curLimit), .gateA(gateA), .gateB(gateB),
    .periodStart(periodStart)
  );

  int    checkCnt = 0;
  int    failCnt = 0;
  string curReq = "R1";
  bit    checkOn = 0;

  function automatic void chk(string req, string what, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  // Behavioural reference model
  int mCnt, mDone, mWasOn, mFired, mSteer, mArmed;
  int syncQ[$] = '{0, 0, 0, 0};

  function automatic int mPulse();
    return (mCnt >= int'(blankLen)) && (mCnt < int'(dutyCmd)) && !mDone
           && !curLimit && !shutdown && mArmed;
  endfunction

  logic pA = 1'b0, pB = 1'b0;
  int   lastOut = -1;
  int   riseCnt = 0;

  always @(posedge clk) begin
    int fire, tick, pul;
    if (!rstN) begin
      mCnt = 0; mDone = 0; mWasOn = 0; mFired = 0; mSteer = 0; mArmed = 0;
      syncQ = '{0, 0, 0, 0};
    end else begin
      fire = (syncQ[1] != 0) && (syncQ[2] != 0) && (syncQ[3] == 0);
      tick = (mCnt >= int'(periodMax)) || fire;
      pul  = mPulse();
      if (tick) begin
        if (mFired || pul) mSteer = 1 - mSteer;
        mCnt = 0; mDone = 0; mWasOn = 0; mFired = 0;
        mArmed = shutdown ? 0 : 1;
      end else begin
        mDone  = mDone || curLimit || (mWasOn && !pul);
        mWasOn = pul;
        mFired = mFired || pul;
        mCnt++;
        if (shutdown) mArmed = 0;
      end
      syncQ.push_front(int'(syncIn));
      void'(syncQ.pop_back());
    end
    #2;
    if (rstN && checkOn) begin
      pul = mPulse();
      chk(curReq, "gateA vs model", int'(gateA), int'(pul && !mSteer));
      chk(curReq, "gateB vs model", int'(gateB), int'(pul && mSteer));
      chk(curReq, "periodStart vs model", int'(periodStart), int'(mCnt == 0));
      // Independent output monitors
      if (periodStart) riseCnt = 0;
      if (gateA && !pA) begin
        if (lastOut >= 0) chk("R3", "alternation on A rise", lastOut, 1);
        lastOut = 0; riseCnt++;
      end
      if (gateB && !pB) begin
        if (lastOut >= 0) chk("R3", "alternation on B rise", lastOut, 0);
        lastOut = 1; riseCnt++;
      end
      if (riseCnt > 1) chk("R6", "pulses in one period", riseCnt, 1);
      pA = gateA; pB = gateB;
    end
  end

  task automatic alignStart();
    do begin @(negedge clk); #1; end while (!periodStart);
  endtask

  task automatic measurePeriod(string req, int exp);
    int n = 0;
    alignStart();
    do begin @(negedge clk); #1; n++; end while (!periodStart && n < 300);
    chk(req, "period length", n, exp);
  endtask

  // Count enable-on cycles over one full period, and the index of the first
  task automatic onePeriod(output int onCyc, output int firstOn);
    onCyc = 0; firstOn = -1;
    alignStart();
    for (int c = 0; c <= int'(periodMax); c++) begin
      if (c > 0) begin @(negedge clk); #1; end
      if (gateA || gateB) begin
        onCyc++;
        if (firstOn < 0) firstOn = c;
      end
    end
  endtask

  task automatic runTests();
    int onCyc, firstOn, n;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "gateA in reset", int'(gateA), 0);
    chk("R1", "gateB in reset", int'(gateB), 0);
    chk("R1", "periodStart in reset", int'(periodStart), 1);
    rstN = 1'b1;
    #0.5;
    chk("R1", "gates after release", int'(gateA | gateB), 0);
    checkOn = 1;
    onCyc = 0;
    for (int c = 1; c < 20; c++) begin
      @(negedge clk); #1;
      onCyc += int'(gateA | gateB);
    end
    chk("R1", "no pulse in first period", onCyc, 0);
    @(negedge clk); #1;
    @(negedge clk); #1; @(negedge clk); #1; @(negedge clk); #1;
    chk("R1", "first pulse on A", int'(gateA), 1);

    // R2: period length
    curReq = "R2";
    measurePeriod("R2", 20);
    periodMax = 8'd11;
    measurePeriod("R2", 12);
    periodMax = 8'd19;
    measurePeriod("R2", 20);

    // R5 / R4: compare thresholds and blanking
    curReq = "R5";
    dutyCmd = 8'd10;
    onePeriod(onCyc, firstOn);
    chk("R5", "on-time duty 10", onCyc, 7);
    chk("R4", "first on cycle after blank", firstOn, 3);
    dutyCmd = 8'd255;
    onePeriod(onCyc, firstOn);
    chk("R5", "on-time at max command", onCyc, 17);
    chk("R4", "blanking with max command", firstOn, 3);
    dutyCmd = 8'd3;
    onePeriod(onCyc, firstOn);
    chk("R5", "on-time at zero threshold", onCyc, 0);
    dutyCmd = 8'd1;
    onePeriod(onCyc, firstOn);
    chk("R5", "on-time below threshold", onCyc, 0);
    curReq = "R3";
    dutyCmd = 8'd8;
    repeat (4) onePeriod(onCyc, firstOn);

    // R6: compare glitch inside a period
    curReq = "R6";
    dutyCmd = 8'd12;
    alignStart();
    onCyc = int'(gateA | gateB);
    for (int c = 1; c < 20; c++) begin
      @(negedge clk); #1;
      onCyc += int'(gateA | gateB);
      if (c == 6) dutyCmd = 8'd4;
      if (c == 8) dutyCmd = 8'd15;
    end
    chk("R6", "on-time with glitching compare", onCyc, 4);
    onePeriod(onCyc, firstOn);
    chk("R6", "next period full pulse", onCyc, 12);

    // R7 / R8: shutdown mid-pulse, timing kept, re-arm waits
    curReq = "R7";
    alignStart();
    repeat (5) begin @(negedge clk); #1; end
    chk("R7", "pulse before shutdown", int'(gateA | gateB), 1);
    shutdown = 1'b1;
    #0.5;
    chk("R7", "gates off at shutdown", int'(gateA | gateB), 0);
    measurePeriod("R7", 20);
    curReq = "R8";
    alignStart();
    repeat (5) begin @(negedge clk); #1; end
    shutdown = 1'b0;
    onCyc = 0;
    for (int c = 5; c < 20; c++) begin
      if (c > 5) begin @(negedge clk); #1; end
      onCyc += int'(gateA | gateB);
    end
    chk("R8", "off after release until period end", onCyc, 0);
    repeat (3) onePeriod(onCyc, firstOn);
    // shutdown before the pulse fires, held across one boundary
    curReq = "R3";
    alignStart();
    @(negedge clk); #1;
    shutdown = 1'b1;
    alignStart();
    repeat (2) begin @(negedge clk); #1; end
    shutdown = 1'b0;
    repeat (4) onePeriod(onCyc, firstOn);

    // R9: sync restart and glitch rejection
    curReq = "R9";
    dutyCmd = 8'd10;
    alignStart();
    n = 0;
    do begin
      @(negedge clk); #1; n++;
      if (n == 8)  syncIn = 1'b1;
      if (n == 10) syncIn = 1'b0;
    end while (!periodStart && n < 300);
    chk("R9", "period restarted by sync", n, 12);
    alignStart();
    n = 0;
    do begin
      @(negedge clk); #1; n++;
      if (n == 8) syncIn = 1'b1;
      if (n == 9) syncIn = 1'b0;
    end while (!periodStart && n < 300);
    chk("R9", "one-sample sync ignored", n, 20);

    // R10: current limit
    curReq = "R10";
    dutyCmd = 8'd12;
    alignStart();
    onCyc = int'(gateA | gateB);
    for (int c = 1; c < 20; c++) begin
      @(negedge clk); #1;
      onCyc += int'(gateA | gateB);
      if (c == 4) begin
        curLimit = 1'b1;
        #0.5;
        chk("R10", "gates off at current limit", int'(gateA | gateB), 0);
      end
      if (c == 5) curLimit = 1'b0;
    end
    chk("R10", "on-time cut by current limit", onCyc, 2);
    onePeriod(onCyc, firstOn);
    chk("R10", "next period recovers", onCyc, 9);
    @(negedge clk);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (20000) @(posedge clk);
        failCnt++; checkCnt++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule